// File: doc/BRIEF.md
# Watermark-Paced Slave FIFO Read Controller

This block sits on the FPGA side of a synchronous slave-FIFO link to a USB bridge device. It pulls 32-bit words out of the bridge's inbound buffer by driving a read strobe. The bridge offers inbound data one buffer at a time and gives two flags for the thread: a buffer-ready flag and a partial (watermark) flag. The controller has no empty flag to work from. It relies on the watermark rule instead. Once the partial flag has been seen high, only a fixed number of words remain in the buffer. The controller reads exactly those words and then waits for the next buffer.

Software programs the payload length in words and pulses `start`. The host may send pad words so that a short final buffer still holds a full watermark tail. The controller reads those pad words to empty the buffer, but it counts them and drops them instead of forwarding them. Payload words leave in order on a valid/ready stream. A small skid store absorbs the words still in flight from the bridge. A one-cycle `done` pulse closes the transfer.

Top module: `wm_fifo_reader`

## Requirements
- R1: After reset, `fifo_rd`, `m_valid`, `done` and `busy` are low and `pad_count` is zero.
- R2: A `start` pulse while idle loads `len_words` (a word count of at least 1) and raises `busy`. A `start` pulse while busy is ignored: the transfer in progress keeps its length and no second transfer follows it.
- R3: `fifo_rd` is high only while `fifo_rdy_flag` is high. Every word of every offered buffer is read, and none beyond it. The partial flag rises when WM words or fewer remain, where WM is 6 by default. If the strobe is high in the cycle the partial flag is first sampled high, exactly WM*(32/BUS_W)-1 more strobes follow (5 by default). If the strobe is low in that cycle, exactly WM more follow. After that the controller waits for a new buffer.
- R4: If the partial flag is already high in the first cycle a new buffer shows ready, the controller issues exactly the tail count of strobes (5 by default) for that buffer.
- R5: The word for a strobe issued in the cycle ending at edge E is taken from `fifo_data` at edge E+RD_LAT, with RD_LAT equal to 2 by default.
- R6: The first `len_words` words read in a transfer are forwarded on `m_data` in read order. Every later word is dropped, and `pad_count` ends the transfer equal to the number of dropped words.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value. No word is lost under any back-pressure pattern, and the skid store never holds more than SKID_DEPTH words.
- R8: `done` is high for exactly one cycle per transfer. It rises after the last payload word has been accepted and after the final buffer has been fully read. `busy` is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the link and the stream |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a transfer when idle |
| len_words | input | LEN_W | Payload length in words, sampled with `start` |
| busy | output | 1 | High from start until the done pulse |
| fifo_rdy_flag | input | 1 | Bridge buffer for the thread holds data |
| fifo_wm_flag | input | 1 | Partial flag: the watermark level has been reached |
| fifo_rd | output | 1 | Read strobe to the bridge, active high |
| fifo_data | input | BUS_W | Read data bus from the bridge |
| m_valid | output | 1 | Stream word available |
| m_ready | input | 1 | Stream consumer accepts a word |
| m_data | output | BUS_W | Stream payload word |
| done | output | 1 | One-cycle end-of-transfer pulse |
| pad_count | output | LEN_W | Words dropped beyond the payload in this transfer |

## Verification
The assertions assume that the bridge keeps its promises. The ready flag falls for at least one cycle between buffers. The partial flag is high exactly when the number of unread words is between 1 and WM. A buffer that first appears with the partial flag already high holds exactly the tail count of words. The bench's bridge model meets these terms by construction. It offers only buffers larger than WM, or short buffers padded to exactly five words. It gaps the ready flag for two cycles between buffers, and it updates both flags from its own count of unread words. Back-pressure on `m_ready` is driven as always-on, as a pseudo-random 50% pattern, and as mostly-off.

// File: rtl/wmr_pkg.sv
package wmr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_TAIL,
    ST_DRAIN,
    ST_DONE
  } wmr_state_e;

  // strobes still allowed after the one taken at the partial-flag edge
  function automatic int tail_words(input int wm, input int bus_w);
    return wm * (32 / bus_w) - 1;
  endfunction

endpackage

// File: rtl/wmr_lat_pipe.sv
// Tracks strobes in flight toward the capture edge, with a keep/drop tag per word.
module wmr_lat_pipe #(
  parameter int LAT = 2,
  parameter int CW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          issue_keep,
  output logic          cap_valid,
  output logic          cap_keep,
  output logic [CW-1:0] inflight
);

  logic [LAT-1:0] v_sr;
  logic [LAT-1:0] k_sr;

  generate
    if (LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          v_sr <= '0;
          k_sr <= '0;
        end else begin
          v_sr <= issue;
          k_sr <= issue & issue_keep;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          v_sr <= '0;
          k_sr <= '0;
        end else begin
          v_sr <= {v_sr[LAT-2:0], issue};
          k_sr <= {k_sr[LAT-2:0], issue & issue_keep};
        end
      end
    end
  endgenerate

  assign cap_valid = v_sr[LAT-1];
  assign cap_keep  = k_sr[LAT-1];

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + CW'(issue) - CW'(cap_valid);
  end

endmodule

// File: rtl/wmr_skid_fifo.sv
// Small skid store for captured payload words. The storage array has no reset so it can map to RAM.
module wmr_skid_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [LVL_W-1:0] level
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic          pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (level != '0);
  assign out_data  = mem[rd_ptr];
  assign pop       = rd_en && out_valid;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (pop)   rd_ptr <= bump(rd_ptr);
      level <= level + LVL_W'(wr_en) - LVL_W'(pop);
    end
  end

endmodule

// File: rtl/wmr_ctrl.sv
// Transfer sequencer: buffer hand-off, watermark tail count, payload countdown.
module wmr_ctrl
  import wmr_pkg::*;
#(
  parameter int WM    = 6,
  parameter int BUS_W = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len_words,
  input  logic             rdy_flag,
  input  logic             wm_flag,
  input  logic             credit_ok,
  input  logic             drained,
  output logic             rd_issue,
  output logic             rd_keep,
  output logic             xfer_load,
  output logic             busy,
  output logic             done
);

  localparam int TAILW = tail_words(WM, BUS_W);
  localparam int TW    = $clog2(TAILW + 2);

  wmr_state_e       st;
  logic [LEN_W-1:0] pay_rem;
  logic [LEN_W-1:0] pay_next;
  logic [TW-1:0]    tail_cnt;
  logic             take_pay;

  assign rd_issue  = credit_ok && ((st == ST_READ) || (st == ST_TAIL));
  assign rd_keep   = (pay_rem != '0);
  assign take_pay  = rd_issue && rd_keep;
  assign pay_next  = pay_rem - LEN_W'(take_pay);
  assign xfer_load = (st == ST_IDLE) && start;
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      pay_rem  <= '0;
      tail_cnt <= '0;
      done     <= 1'b0;
    end else begin
      done    <= 1'b0;
      pay_rem <= pay_next;
      case (st)
        ST_IDLE: begin
          if (start) begin
            pay_rem <= len_words;
            st      <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rdy_flag) begin
            if (wm_flag && (TAILW > 0)) begin
              tail_cnt <= TW'(TAILW);
              st       <= ST_TAIL;
            end else begin
              st <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (wm_flag) begin
            if (!rd_issue) begin
              tail_cnt <= TW'(TAILW + 1);
              st       <= ST_TAIL;
            end else if (TAILW > 0) begin
              tail_cnt <= TW'(TAILW);
              st       <= ST_TAIL;
            end else begin
              st <= (pay_next == '0) ? ST_DRAIN : ST_WAIT;
            end
          end
        end
        ST_TAIL: begin
          if (rd_issue) begin
            tail_cnt <= tail_cnt - 1'b1;
            if (tail_cnt == TW'(1)) st <= (pay_next == '0) ? ST_DRAIN : ST_WAIT;
          end
        end
        ST_DRAIN: begin
          if (drained) begin
            st   <= ST_DONE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wm_fifo_reader.sv
module wm_fifo_reader #(
  parameter int BUS_W      = 32,
  parameter int WM         = 6,
  parameter int RD_LAT     = 2,
  parameter int LEN_W      = 16,
  parameter int SKID_DEPTH = RD_LAT + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len_words,
  output logic             busy,
  input  logic             fifo_rdy_flag,
  input  logic             fifo_wm_flag,
  output logic             fifo_rd,
  input  logic [BUS_W-1:0] fifo_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [BUS_W-1:0] m_data,
  output logic             done,
  output logic [LEN_W-1:0] pad_count
);

  localparam int IFW = $clog2(RD_LAT + 1);
  localparam int FCW = $clog2(SKID_DEPTH + 1);

  logic           rd_issue;
  logic           rd_keep;
  logic           xfer_load;
  logic           cap_valid;
  logic           cap_keep;
  logic [IFW-1:0] inflight;
  logic [FCW-1:0] fifo_cnt;
  logic           credit_ok;
  logic           drained;

  assign credit_ok = (int'(fifo_cnt) + int'(inflight)) < SKID_DEPTH;
  assign drained   = (fifo_cnt == '0) && (inflight == '0);
  assign fifo_rd   = rd_issue;

  wmr_ctrl #(
    .WM(WM), .BUS_W(BUS_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .len_words(len_words),
    .rdy_flag(fifo_rdy_flag), .wm_flag(fifo_wm_flag),
    .credit_ok(credit_ok), .drained(drained),
    .rd_issue(rd_issue), .rd_keep(rd_keep), .xfer_load(xfer_load),
    .busy(busy), .done(done)
  );

  wmr_lat_pipe #(
    .LAT(RD_LAT), .CW(IFW)
  ) u_pipe (
    .clk(clk), .rst(rst), .issue(rd_issue), .issue_keep(rd_keep),
    .cap_valid(cap_valid), .cap_keep(cap_keep), .inflight(inflight)
  );

  wmr_skid_fifo #(
    .DW(BUS_W), .DEPTH(SKID_DEPTH), .LVL_W(FCW)
  ) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(cap_valid && cap_keep), .wr_data(fifo_data),
    .rd_en(m_ready), .out_valid(m_valid), .out_data(m_data),
    .level(fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || xfer_load) pad_count <= '0;
    else if (cap_valid && !cap_keep) pad_count <= pad_count + 1'b1;
  end

endmodule

// File: rtl/wmr_chk.sv
module wmr_chk #(
  parameter int WM    = 6,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int FCW   = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           fifo_rdy_flag,
  input logic           fifo_wm_flag,
  input logic           fifo_rd,
  input logic           busy,
  input logic           done,
  input logic           m_valid,
  input logic           m_ready,
  input logic [DW-1:0]  m_data,
  input logic [FCW-1:0] fifo_cnt
);

  logic [7:0] wm_reads;

  always_ff @(posedge clk) begin
    if (rst || !fifo_rdy_flag)           wm_reads <= '0;
    else if (fifo_rd && fifo_wm_flag)    wm_reads <= wm_reads + 1'b1;
  end

  AST_RD_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> fifo_rdy_flag);                                             // R3
  AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (fifo_rd && fifo_wm_flag) |-> (int'(wm_reads) < WM));                   // R3
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fifo_rd);                                                    // R2
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));                // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(fifo_cnt) <= DEPTH);                                               // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !busy));                                             // R8

endmodule

bind wm_fifo_reader wmr_chk #(
  .WM(WM), .DW(BUS_W), .DEPTH(SKID_DEPTH), .FCW(FCW)
) u_chk (
  .clk(clk), .rst(rst), .fifo_rdy_flag(fifo_rdy_flag), .fifo_wm_flag(fifo_wm_flag),
  .fifo_rd(fifo_rd), .busy(busy), .done(done), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .fifo_cnt(fifo_cnt)
);

// File: tb/tb_wm_fifo_reader.sv
module tb_wm_fifo_reader;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WM    = 6;
  localparam int LEN_W = 16;
  localparam logic [31:0] TAG = 32'hA500_0000;
  localparam logic [31:0] BAD = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LEN_W-1:0] len_words = '0;
  logic busy, fifo_rd, m_valid, done;
  logic m_ready = 1'b0;
  logic [31:0] m_data;
  logic [LEN_W-1:0] pad_count;
  logic fifo_rdy_flag, fifo_wm_flag;
  logic [31:0] fifo_data;

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // bridge model
  int sizes[8];
  int nbufs = 0;
  int nb_idx = 0;
  int cur_rem = 0;
  int gap = 0;
  int overreads = 0;
  int w_idx = 0;
  logic bld = 1'b0;
  logic [31:0] dq0 = BAD, dq1 = BAD;

  assign fifo_rdy_flag = (cur_rem > 0);
  assign fifo_wm_flag  = (cur_rem > 0) && (cur_rem <= WM);
  assign fifo_data     = dq1;

  always @(posedge clk) begin
    int rem_after;
    dq1 <= dq0;
    if (bld) begin
      nb_idx <= 0; cur_rem <= 0; gap <= 2; dq0 <= BAD;
    end else begin
      rem_after = cur_rem;
      if (fifo_rd) begin
        if (cur_rem == 0) begin
          overreads <= overreads + 1;
          dq0 <= BAD;
        end else begin
          dq0 <= TAG + 32'(w_idx);
          w_idx <= w_idx + 1;
          rem_after = cur_rem - 1;
        end
      end else begin
        dq0 <= BAD;
      end
      cur_rem <= rem_after;
      if (rem_after == 0 && nb_idx < nbufs) begin
        if (gap > 0) gap <= gap - 1;
        else begin
          cur_rem <= sizes[nb_idx];
          nb_idx  <= nb_idx + 1;
          gap     <= 2;
        end
      end
    end
  end

  wm_fifo_reader dut (
    .clk(clk), .rst(rst), .start(start), .len_words(len_words), .busy(busy),
    .fifo_rdy_flag(fifo_rdy_flag), .fifo_wm_flag(fifo_wm_flag), .fifo_rd(fifo_rd),
    .fifo_data(fifo_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .done(done), .pad_count(pad_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard and monitor
  logic [31:0] exp_q[$];
  int mode = 0;
  int done_cnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_v = 0, prev_r = 0, prev_done = 0;
  logic [31:0] prev_d = '0;

  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: m_ready = 1'b1;
        1: m_ready = lfsr[0];
        default: m_ready = lfsr[0] & lfsr[3];
      endcase
      #1;
      if (!rst) begin
        if (prev_v && !prev_r)
          chk(m_valid && (m_data == prev_d), "R7", "held word under back-pressure",
              {m_valid, m_data}, {1'b1, prev_d});
        if (m_valid && m_ready) begin
          if (exp_q.size() == 0) chk(0, "R6", "unexpected stream word", m_data, 0);
          else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(m_data == e, "R6", "payload word order/value (R5 capture)", m_data, e);
          end
        end
        if (done) begin
          done_cnt++;
          chk(exp_q.size() == 0, "R8", "payload left at done", exp_q.size(), 0);
          if (prev_done) chk(0, "R8", "done longer than one cycle", 2, 1);
        end
        prev_v = m_valid; prev_r = m_ready; prev_d = m_data; prev_done = done;
      end
    end
  end

  int exp_base = 0;

  task automatic run_xfer(input int len, input int nb, input int s0, input int s1,
                          input int s2, input int s3, input int exp_pad,
                          input int rmode, input bit poke);
    int d0;
    int tot;
    sizes[0] = s0; sizes[1] = s1; sizes[2] = s2; sizes[3] = s3;
    nbufs = nb;
    tot = s0 + ((nb > 1) ? s1 : 0) + ((nb > 2) ? s2 : 0) + ((nb > 3) ? s3 : 0);
    for (int i = 0; i < len; i++) exp_q.push_back(TAG + 32'(exp_base + i));
    exp_base += tot;
    mode = rmode;
    d0 = done_cnt;
    @(negedge clk);
    bld = 1'b1; start = 1'b1; len_words = LEN_W'(len);
    @(negedge clk);
    bld = 1'b0; start = 1'b0; len_words = '0;
    @(negedge clk);
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; len_words = LEN_W'(7);
      @(negedge clk);
      start = 1'b0; len_words = '0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(done_cnt == d0 + 1, "R8", "done pulses per transfer", done_cnt - d0, 1);
    chk(busy == 1'b0, "R8", "busy low after done (R2 no restart)", busy, 0);
    chk(pad_count == LEN_W'(exp_pad), "R6", "dropped word count", pad_count, exp_pad);
    chk(overreads == 0, "R3", "strobes beyond buffer end", overreads, 0);
    chk(cur_rem == 0 && nb_idx == nb, "R3", "words left unread in bridge",
        cur_rem, 0);
    chk(w_idx == exp_base, "R4", "total words read", w_idx, exp_base);
    chk(exp_q.size() == 0, "R6", "payload words not delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!fifo_rd && !m_valid && !done && !busy, "R1", "outputs after reset",
        {fifo_rd, m_valid, done, busy}, 0);
    chk(pad_count == '0, "R1", "pad count after reset", pad_count, 0);
    // R3: whole buffers, no padding
    run_xfer(30, 2, 16, 14, 0, 0, 0, 0, 0);
    // R4: short padded final buffer of exactly the tail count
    run_xfer(33, 3, 16, 16, 5, 0, 4, 1, 0);
    // R6 pads mid-buffer, R7 heavy back-pressure, R2 start while busy
    run_xfer(20, 2, 16, 12, 0, 0, 8, 2, 1);
    // R4 single short buffer
    run_xfer(5, 1, 5, 0, 0, 0, 0, 1, 0);
    // R3 several buffers, random back-pressure
    run_xfer(40, 4, 9, 9, 9, 13, 0, 1, 0);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    report();
  end

endmodule